// File: doc/BRIEF.md
# Standby Wake-Up Clock Sequencer

This block controls the clock of a processor core that has a low-power standby mode. Software writes four small registers through a simple write port. The first is a PLL control word with a power-up bit and a clock-select bit. The second is a frequency word that holds the multiplier, input-divider and output-divider fields. The third is a power word: its await bit puts the core into standby, and a second bit chooses whether the PLL is powered down during standby. The fourth is a lock-wait count.

When the core is in standby, a wake event starts the resume sequence. The sequencer counts a fixed latency of three clock cycles and then issues a one-cycle resume strobe. If the PLL drives the core clock but was powered down during standby, the sequencer first powers the PLL up and counts a programmable lock wait. The three-cycle count starts only after that wait. The analog PLL is not modelled: the lock time is a cycle count, and the clock-mux select is a plain output.

Top module: `wake_clk_seq`

## Requirements
- R1: After reset, clk_sel_o, pll_pwr_o, stby_o and resume_o are 0, and mult_o, idiv_o and odiv_o are 0.
- R2: A write to address 0 sets the power-up bit from data bit 1 and the select bit from data bit 0. While running, pll_pwr_o equals the power-up bit and clk_sel_o equals the select bit.
- R3: A write to address 0 with data bit 0 = 1 and data bit 1 = 0 leaves clk_sel_o at 0, so an unpowered PLL is never selected.
- R4: A write to address 1 loads the frequency word. mult_o shows bits 8:0, idiv_o shows bits 13:9 and odiv_o shows bits 15:14.
- R5: A write to address 2 with bit 15 = 1 raises stby_o on the following cycle. Bit 14 of the same write, when 1, holds pll_pwr_o at 0 for the whole standby period.
- R6: If the PLL is deselected, or was not powered down in standby, resume_o rises exactly 3 cycles after the clock edge that samples wake_i.
- R7: If the PLL is selected and was powered down in standby, resume_o rises exactly 3+N cycles after the wake edge. N is the value written to address 3, and pll_pwr_o is 1 from the wake edge onwards.
- R8: wake_i has no effect while the core is running, or while the lock wait or the latency count is in progress.
- R9: resume_o is high for exactly one cycle. stby_o is 0 from that cycle onwards, and the await bit is cleared, so the core stays running with no new wake or write.
- R10: Register writes are ignored while the core is in standby or resuming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 frequency, 2 power, 3 lock count |
| wr_data_i | input | 16 | Register write data |
| wake_i | input | 1 | Wake event |
| pll_pwr_o | output | 1 | PLL power-up request |
| clk_sel_o | output | 1 | Clock mux select: 1 for PLL, 0 for raw input clock |
| stby_o | output | 1 | Core is in standby |
| resume_o | output | 1 | One-cycle resume-execution strobe |
| mult_o | output | 9 | Multiplier field |
| idiv_o | output | 5 | Input-divider field |
| odiv_o | output | 2 | Output-divider field |

## Verification
The assertions assume the following about the inputs:
- wake_i is a synchronous level.
- The latency count parameter is at least one.
- Writes may arrive in any state, because the sequencer gates them itself.

The directed stimulus drives every input half a period away from the active edge. It uses wake pulses one cycle wide, and small lock counts (0, 1 and 20) so each lock path finishes quickly. It deliberately pulses wake_i during the latency count and writes registers during standby, to exercise the paths that ignore these inputs.

// File: rtl/wake_clk_seq_pkg.sv
package wake_clk_seq_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_FREQ = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_PWR  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_LOCK = 2'd3;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_STBY,
    ST_LOCK,
    ST_LAT,
    ST_RESUME
  } seq_state_e;
endpackage

// File: rtl/seq_regs.sv
module seq_regs
  import wake_clk_seq_pkg::*;
#(
  parameter int unsigned LOCK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pll_en_o,
  output logic              pll_sel_o,
  output logic [DATA_W-1:0] freq_o,
  output logic              stby_off_o,
  output logic              await_req_o,
  output logic [LOCK_W-1:0] lock_cyc_o
);
  logic wr_ok;
  assign wr_ok = wr_en_i && run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pll_en_o   <= 1'b0;
      pll_sel_o  <= 1'b0;
      freq_o     <= '0;
      stby_off_o <= 1'b0;
      lock_cyc_o <= '0;
    end else if (wr_ok) begin
      unique case (wr_addr_i)
        ADR_CTRL: begin
          pll_en_o  <= wr_data_i[1];
          // select only sticks when the same write powers the PLL
          pll_sel_o <= wr_data_i[0] & wr_data_i[1];
        end
        ADR_FREQ: freq_o     <= wr_data_i;
        ADR_PWR:  stby_off_o <= wr_data_i[14];
        default:  lock_cyc_o <= wr_data_i[LOCK_W-1:0];
      endcase
    end
  end

  assign await_req_o = wr_ok && (wr_addr_i == ADR_PWR) && wr_data_i[15];

  a_r3_sel_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_sel_o |-> pll_en_o);
  a_r10_no_write_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable({pll_en_o, pll_sel_o, freq_o, stby_off_o, lock_cyc_o}));
endmodule

// File: rtl/seq_lock_cnt.sv
module seq_lock_cnt #(
  parameter int unsigned LOCK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LOCK_W-1:0] val_i,
  output logic              done_o
);
  logic [LOCK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // last cycle of the wait
  assign done_o = (cnt_q == LOCK_W'(1));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import wake_clk_seq_pkg::*;
#(
  parameter int unsigned LOCK_W  = 16,
  parameter int unsigned LAT_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              await_req_i,
  input  logic              wake_i,
  input  logic              need_lock_i,
  input  logic [LOCK_W-1:0] lock_cyc_i,
  input  logic              lock_done_i,
  output logic              lock_load_o,
  output logic              run_o,
  output logic              stby_o,
  output logic              lock_busy_o,
  output logic              resume_o
);
  localparam int unsigned LAT_W = (LAT_CYC > 1) ? $clog2(LAT_CYC) : 1;

  seq_state_e       state_q, state_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             go_lock;

  assign go_lock     = need_lock_i && (lock_cyc_i != '0);
  assign lock_load_o = (state_q == ST_STBY) && wake_i && go_lock;

  always_comb begin
    state_d = state_q;
    lat_d   = lat_q;
    unique case (state_q)
      ST_RUN:  if (await_req_i) state_d = ST_STBY;
      ST_STBY: if (wake_i) begin
        state_d = go_lock ? ST_LOCK : ST_LAT;
        lat_d   = '0;
      end
      ST_LOCK: if (lock_done_i) begin
        state_d = ST_LAT;
        lat_d   = '0;
      end
      ST_LAT: begin
        if (lat_q == LAT_W'(LAT_CYC - 1)) state_d = ST_RESUME;
        else                              lat_d   = lat_q + 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      lat_q   <= '0;
    end else begin
      state_q <= state_d;
      lat_q   <= lat_d;
    end
  end

  assign run_o       = (state_q == ST_RUN);
  assign stby_o      = (state_q == ST_STBY) || (state_q == ST_LOCK) || (state_q == ST_LAT);
  assign lock_busy_o = (state_q == ST_LOCK);
  assign resume_o    = (state_q == ST_RESUME);

  a_r9_resume_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o && run_o);
  a_r6_lat_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LAT) |-> (lat_q < LAT_W'(LAT_CYC)));
  a_r8_wake_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_LAT) && wake_i) |=> (state_q == ST_LAT || state_q == ST_RESUME));
  a_r8_run_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && wake_i && !await_req_i) |=> run_o);
endmodule

// File: rtl/wake_clk_seq.sv
module wake_clk_seq
  import wake_clk_seq_pkg::*;
#(
  parameter int unsigned LOCK_W  = 16,
  parameter int unsigned LAT_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wake_i,
  output logic              pll_pwr_o,
  output logic              clk_sel_o,
  output logic              stby_o,
  output logic              resume_o,
  output logic [8:0]        mult_o,
  output logic [4:0]        idiv_o,
  output logic [1:0]        odiv_o
);
  logic              pll_en, pll_sel, stby_off, await_req, run;
  logic              lock_load, lock_done, lock_busy, in_stby;
  logic [DATA_W-1:0] freq;
  logic [LOCK_W-1:0] lock_cyc;

  seq_regs #(.LOCK_W(LOCK_W)) u_regs (
    .clk_i, .rst_ni,
    .run_i       (run),
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .pll_en_o    (pll_en),
    .pll_sel_o   (pll_sel),
    .freq_o      (freq),
    .stby_off_o  (stby_off),
    .await_req_o (await_req),
    .lock_cyc_o  (lock_cyc)
  );

  seq_lock_cnt #(.LOCK_W(LOCK_W)) u_lock (
    .clk_i, .rst_ni,
    .load_i (lock_load),
    .val_i  (lock_cyc),
    .done_o (lock_done)
  );

  seq_fsm #(.LOCK_W(LOCK_W), .LAT_CYC(LAT_CYC)) u_fsm (
    .clk_i, .rst_ni,
    .await_req_i (await_req),
    .wake_i,
    .need_lock_i (pll_sel && stby_off),
    .lock_cyc_i  (lock_cyc),
    .lock_done_i (lock_done),
    .lock_load_o (lock_load),
    .run_o       (run),
    .stby_o      (stby_o),
    .lock_busy_o (lock_busy),
    .resume_o    (resume_o)
  );

  logic pre_wake;
  assign pre_wake = stby_o && !lock_busy && !resume_o;
  assign in_stby  = pre_wake && !(run || lock_busy);

  // PLL is dropped only while truly asleep and before the wake edge
  logic stby_idle_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stby_idle_q <= 1'b0;
    else if (run)     stby_idle_q <= await_req;
    else if (wake_i)  stby_idle_q <= 1'b0;
  end

  assign pll_pwr_o = pll_en && !(stby_off && stby_idle_q && in_stby);
  assign clk_sel_o = pll_sel;
  assign mult_o    = freq[8:0];
  assign idiv_o    = freq[13:9];
  assign odiv_o    = freq[15:14];

  a_r7_lock_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_busy |-> pll_pwr_o);
  a_r5_sel_hold_stby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_o && $past(stby_o)) |-> $stable(clk_sel_o));
endmodule

// File: tb/wake_clk_seq_test.sv
module wake_clk_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wake = 1'b0;
  logic        pll_pwr, clk_sel, stby, resume;
  logic [8:0]  mult;
  logic [4:0]  idiv;
  logic [1:0]  odiv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wake_clk_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wake_i(wake), .pll_pwr_o(pll_pwr), .clk_sel_o(clk_sel),
    .stby_o(stby), .resume_o(resume), .mult_o(mult), .idiv_o(idiv), .odiv_o(odiv)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // pulse wake, return edges until resume seen; optional extra wake during latency
  task automatic wake_measure(bit extra, output int n);
    @(negedge clk); wake = 1'b1;
    @(posedge clk); #1; wake = 1'b0;
    n = 0;
    while (!resume && n < 500) begin
      if (extra && n == 1) wake = 1'b1;
      @(posedge clk); #1;
      wake = 1'b0;
      n++;
    end
  endtask

  task automatic t_reset();
    chk("R1 clk_sel", clk_sel, 0); chk("R1 pll_pwr", pll_pwr, 0);
    chk("R1 stby", stby, 0);       chk("R1 resume", resume, 0);
    chk("R1 fields", {mult, idiv, odiv}, 0);
  endtask

  task automatic t_ctrl();
    wr(2'd0, 16'h0003);
    chk("R2 pll_pwr", pll_pwr, 1); chk("R2 clk_sel", clk_sel, 1);
    wr(2'd0, 16'h0002);
    chk("R2 deselect", clk_sel, 0); chk("R2 still powered", pll_pwr, 1);
    wr(2'd0, 16'h0001);
    chk("R3 rejected sel", clk_sel, 0); chk("R3 power off", pll_pwr, 0);
  endtask

  task automatic t_freq();
    wr(2'd1, 16'b10_10110_101010101);
    chk("R4 mult", mult, 9'b101010101); chk("R4 idiv", idiv, 5'b10110);
    chk("R4 odiv", odiv, 2'b10);
    wr(2'd1, 16'b01_00011_000000111);
    chk("R4 mult b", mult, 7); chk("R4 idiv b", idiv, 3); chk("R4 odiv b", odiv, 1);
  endtask

  task automatic t_wake_in_run();
    int seen = 0;
    @(negedge clk); wake = 1'b1;
    tick(); wake = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (resume || stby) seen++;
      tick();
    end
    chk("R8 wake while running", seen, 0);
  endtask

  task automatic t_path(string tag, logic [15:0] ctrl, bit off, int exp_pwr_stby,
                        int exp_lat, bit extra);
    int n, leak;
    wr(2'd0, ctrl);
    wr(2'd2, {1'b1, off, 14'd0});
    chk({"R5 stby ", tag}, stby, 1);
    chk({"R5 pll_pwr in stby ", tag}, pll_pwr, exp_pwr_stby);
    wake_measure(extra, n);
    chk({tag, " latency"}, n, exp_lat);
    chk({"R9 stby at resume ", tag}, stby, 0);
    tick();
    chk({"R9 single pulse ", tag}, resume, 0);
    leak = 0;
    for (int i = 0; i < 6; i++) begin
      if (stby || resume) leak++;
      tick();
    end
    chk({"R9 await cleared ", tag}, leak, 0);
  endtask

  task automatic t_lock_path(int lk);
    int n;
    bit pw_ok;
    wr(2'd3, lk[15:0]);
    wr(2'd0, 16'h0003);
    wr(2'd2, 16'hC000);
    chk("R5 pll off in stby", pll_pwr, 0);
    wr(2'd0, 16'h0000);  // ignored while asleep
    @(negedge clk); wake = 1'b1;
    @(posedge clk); #1; wake = 1'b0;
    pw_ok = pll_pwr;
    n = 0;
    while (!resume && n < 500) begin
      if (!pll_pwr) pw_ok = 1'b0;
      tick(); n++;
    end
    chk("R7 pll powered during wait", pw_ok, 1);
    chk("R7 latency 3+N", n, 3 + lk);
    chk("R10 ctrl kept", {pll_pwr, clk_sel}, 3);
    tick();
    chk("R9 single pulse lock", resume, 0);
  endtask

  initial begin
    #1;
    t_reset();
    #20 rst_n = 1'b1;
    tick();
    t_reset();
    t_ctrl();
    t_freq();
    t_wake_in_run();
    t_path("R6 deselected off", 16'h0000, 1'b0, 0, 3, 1'b0);
    t_path("R6 selected powered", 16'h0003, 1'b0, 1, 3, 1'b1);
    t_path("R6 deselected pll_off", 16'h0002, 1'b1, 0, 3, 1'b0);
    t_lock_path(20);
    t_lock_path(1);
    t_lock_path(0);
    wr(2'd3, 16'd10);
    t_path("R8 wake during lock", 16'h0003, 1'b1, 0, 13, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule